// File: doc/BRIEF.md
# Single-Precision Float Compare Unit

This block compares two IEEE-754 single-precision operands under one of seven predicates picked by a 3-bit op code. When `valid_i` is high, the comparison is evaluated and registered. One clock later, the block presents a result word that holds the predicate in bit 0.

The predicates differ in how they handle NaN operands, and that handling decides whether the sticky invalid-operation status bit is set:

- Equality and inequality are quiet: only a signaling NaN raises invalid.
- The ordered relations raise invalid on any NaN.
- The unordered test raises invalid only for a signaling NaN.

When a compare raises invalid, the exception capability bit is enabled and the machine exception-enable bit is set, the block pulses an exception request and loads the exception cause register with the floating-point cause code.

Top module: `fcmp_unit`

## Requirements
- R1: One cycle after a clock edge with `valid_i` high, `result_valid_o` is high for one cycle and `result_o` holds the predicate in bit 0 with bits 31..1 zero.
- R2: Op code 0 (unordered) returns 1 when either operand is a NaN, otherwise 0. It raises invalid only when an operand is a signaling NaN.
- R3: Op code 2 (equal) and op code 5 (not-equal) are quiet: a quiet NaN does not raise invalid and a signaling NaN does. Not-equal returns 1 when a NaN is present. +0 and -0 compare equal.
- R4: Op code 1 returns 1 when operand b is less than operand a. Op code 4 returns 1 when operand a is less than operand b. Both return 0 when a NaN is present.
- R5: Op code 3 returns 1 when a is less than or equal to b, and 0 when a NaN is present. Op code 6 returns the inverse of "a less than b", so it returns 1 when a NaN is present.
- R6: The ordered op codes 1, 3, 4 and 6 raise invalid when either operand is any NaN.
- R7: `inv_flag_o` is set one cycle after a compare that raises invalid. It stays set until reset.
- R8: `exc_req_o` pulses one cycle after a compare that raises invalid, but only if `exc_cap_i` and `exc_en_i` were both high with that compare. On that pulse, `exc_cause_o` is loaded with the parameter `FPU_CAUSE` (default 6). Otherwise it keeps its value.
- R9: Op code 7 is reserved. It returns 0 and never raises invalid.
- R10: A NaN has an all-ones exponent and a nonzero fraction. It is signaling when fraction bit 22 is clear and quiet when bit 22 is set.
- R11: During and after reset, `result_o`, `result_valid_o`, `inv_flag_o`, `exc_req_o` and `exc_cause_o` are zero.
- R12: A cycle with `valid_i` low leaves `result_o`, `inv_flag_o` and `exc_cause_o` unchanged and produces no `result_valid_o` or `exc_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare strobe |
| op_i | input | 3 | Predicate select |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| exc_cap_i | input | 1 | Exception capability configured |
| exc_en_i | input | 1 | Machine exception enable |
| result_o | output | 32 | Predicate result word |
| result_valid_o | output | 1 | Result strobe |
| inv_flag_o | output | 1 | Sticky invalid-operation flag |
| exc_req_o | output | 1 | Exception request pulse |
| exc_cause_o | output | 5 | Exception cause register |

## Verification
All results come from registers, so `result_o`, `result_valid_o`, `exc_req_o`, the sticky flag and the cause register each change one clock edge after the strobed cycle. The bench drives the inputs on the falling edge and raises `valid_i` for exactly one rising edge. It then samples every output on the following falling edge, which is one edge later, before the next stimulus can reach the registers. The sticky flag cannot show which compare set it, so the per-vector invalid check uses the exception request with both enables high. The flag itself is checked across sequences of compares and resets.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = WORD_W - 1;

  typedef enum logic [2:0] {
    OP_UN  = 3'd0,
    OP_LT  = 3'd1,
    OP_EQ  = 3'd2,
    OP_LE  = 3'd3,
    OP_GT  = 3'd4,
    OP_NE  = 3'd5,
    OP_GE  = 3'd6,
    OP_RSV = 3'd7
  } cmp_op_e;

  typedef struct packed {
    logic             is_nan;
    logic             is_snan;
    logic             is_zero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } opnd_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output opnd_class_t       cls_o
);
  localparam int QBIT = FRAC_W - 1;

  logic exp_ones, frac_nz;

  always_comb begin
    exp_ones      = &word_i[WORD_W-2 -: EXP_W];
    frac_nz       = |word_i[FRAC_W-1:0];
    cls_o.is_nan  = exp_ones & frac_nz;
    cls_o.is_snan = exp_ones & frac_nz & ~word_i[QBIT];
    cls_o.is_zero = ~|word_i[MAG_W-1:0];
    cls_o.sign    = word_i[WORD_W-1];
    cls_o.mag     = word_i[MAG_W-1:0];
  end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
  import fcmp_pkg::*;
(
  input  cmp_op_e     op_i,
  input  opnd_class_t a_i,
  input  opnd_class_t b_i,
  output logic        pred_o,
  output logic        inv_o
);
  logic any_nan, any_snan, both_zero;
  logic mag_lt_ab, mag_lt_ba, mag_eq;
  logic lt_ab, lt_ba, eq_ab;

  always_comb begin
    any_nan   = a_i.is_nan | b_i.is_nan;
    any_snan  = a_i.is_snan | b_i.is_snan;
    both_zero = a_i.is_zero & b_i.is_zero;
    mag_lt_ab = a_i.mag < b_i.mag;
    mag_lt_ba = b_i.mag < a_i.mag;
    mag_eq    = a_i.mag == b_i.mag;

    // sign-magnitude ordering; zeros of either sign tie
    if (any_nan || both_zero) begin
      lt_ab = 1'b0;
      lt_ba = 1'b0;
    end else if (a_i.sign != b_i.sign) begin
      lt_ab = a_i.sign;
      lt_ba = b_i.sign;
    end else if (!a_i.sign) begin
      lt_ab = mag_lt_ab;
      lt_ba = mag_lt_ba;
    end else begin
      lt_ab = mag_lt_ba;
      lt_ba = mag_lt_ab;
    end
    eq_ab = ~any_nan & (both_zero | ((a_i.sign == b_i.sign) & mag_eq));

    pred_o = 1'b0;
    inv_o  = 1'b0;
    unique case (op_i)
      OP_UN: begin pred_o = any_nan;         inv_o = any_snan; end
      OP_LT: begin pred_o = lt_ba;           inv_o = any_nan;  end
      OP_EQ: begin pred_o = eq_ab;           inv_o = any_snan; end
      OP_LE: begin pred_o = lt_ab | eq_ab;   inv_o = any_nan;  end
      OP_GT: begin pred_o = lt_ab;           inv_o = any_nan;  end
      OP_NE: begin pred_o = ~eq_ab;          inv_o = any_snan; end
      OP_GE: begin pred_o = ~lt_ab;          inv_o = any_nan;  end
      OP_RSV: begin pred_o = 1'b0;           inv_o = 1'b0;     end
      default: begin pred_o = 1'b0;          inv_o = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/fcmp_status.sv
module fcmp_status #(
  parameter int          CAUSE_W   = 5,
  parameter logic [CAUSE_W-1:0] FPU_CAUSE = CAUSE_W'(6)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               inv_i,
  input  logic               exc_cap_i,
  input  logic               exc_en_i,
  output logic               inv_flag_o,
  output logic               exc_req_o,
  output logic [CAUSE_W-1:0] exc_cause_o
);
  logic raise;

  assign raise = fire_i & inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_flag_o  <= 1'b0;
      exc_req_o   <= 1'b0;
      exc_cause_o <= '0;
    end else begin
      if (raise) inv_flag_o <= 1'b1;
      exc_req_o <= raise & exc_cap_i & exc_en_i;
      if (raise && exc_cap_i && exc_en_i) exc_cause_o <= FPU_CAUSE;
    end
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int                 RES_W     = 32,
  parameter int                 CAUSE_W   = 5,
  parameter logic [CAUSE_W-1:0] FPU_CAUSE = CAUSE_W'(6)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         op_i,
  input  logic [WORD_W-1:0]  a_i,
  input  logic [WORD_W-1:0]  b_i,
  input  logic               exc_cap_i,
  input  logic               exc_en_i,
  output logic [RES_W-1:0]   result_o,
  output logic               result_valid_o,
  output logic               inv_flag_o,
  output logic               exc_req_o,
  output logic [CAUSE_W-1:0] exc_cause_o
);
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][WORD_W-1:0] opnd_w;
  opnd_class_t                   opnd_c [N_OPND];
  logic                          pred, inv;

  assign opnd_w[0] = a_i;
  assign opnd_w[1] = b_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fcmp_classify u_cls (
      .word_i (opnd_w[g]),
      .cls_o  (opnd_c[g])
    );
  end

  fcmp_predicate u_pred (
    .op_i   (cmp_op_e'(op_i)),
    .a_i    (opnd_c[0]),
    .b_i    (opnd_c[1]),
    .pred_o (pred),
    .inv_o  (inv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      result_valid_o <= valid_i;
      if (valid_i) result_o <= {{(RES_W-1){1'b0}}, pred};
    end
  end

  fcmp_status #(
    .CAUSE_W   (CAUSE_W),
    .FPU_CAUSE (FPU_CAUSE)
  ) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (valid_i),
    .inv_i       (inv),
    .exc_cap_i   (exc_cap_i),
    .exc_en_i    (exc_en_i),
    .inv_flag_o  (inv_flag_o),
    .exc_req_o   (exc_req_o),
    .exc_cause_o (exc_cause_o)
  );
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
  parameter int                 RES_W     = 32,
  parameter int                 CAUSE_W   = 5,
  parameter logic [CAUSE_W-1:0] FPU_CAUSE = CAUSE_W'(6)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               exc_cap_i,
  input logic               exc_en_i,
  input logic [RES_W-1:0]   result_o,
  input logic               result_valid_o,
  input logic               inv_flag_o,
  input logic               exc_req_o,
  input logic [CAUSE_W-1:0] exc_cause_o
);
  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[RES_W-1:1] == '0);

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(valid_i));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_flag_o |=> inv_flag_o);

  a_r8_req_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> inv_flag_o);

  a_r8_req_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> exc_cause_o == FPU_CAUSE);

  a_r8_req_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> $past(exc_cap_i && exc_en_i && valid_i));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(exc_cause_o) && !exc_req_o);
endmodule

bind fcmp_unit fcmp_unit_chk #(
  .RES_W     (RES_W),
  .CAUSE_W   (CAUSE_W),
  .FPU_CAUSE (FPU_CAUSE)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .exc_cap_i      (exc_cap_i),
  .exc_en_i       (exc_en_i),
  .result_o       (result_o),
  .result_valid_o (result_valid_o),
  .inv_flag_o     (inv_flag_o),
  .exc_req_o      (exc_req_o),
  .exc_cause_o    (exc_cause_o)
);

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] M1 = 32'hBF80_0000, M2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, MZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7FA0_0000;
  localparam logic [31:0] PI = 32'h7F80_0000, MI = 32'hFF80_0000;

  // {op, a, b, expected predicate, expected invalid}
  localparam logic [68:0] VEC [NV] = '{
    {3'd0, P1, P2, 1'b0, 1'b0},
    {3'd0, QN, P1, 1'b1, 1'b0},
    {3'd0, P1, SN, 1'b1, 1'b1},
    {3'd0, PI, P1, 1'b0, 1'b0},
    {3'd0, 32'h7F80_0001, P1, 1'b1, 1'b1},
    {3'd0, P1, 32'h7FFF_FFFF, 1'b1, 1'b0},
    {3'd1, P2, P1, 1'b1, 1'b0},
    {3'd1, P1, P2, 1'b0, 1'b0},
    {3'd1, QN, P1, 1'b0, 1'b1},
    {3'd1, M1, M2, 1'b1, 1'b0},
    {3'd2, P1, P1, 1'b1, 1'b0},
    {3'd2, PZ, MZ, 1'b1, 1'b0},
    {3'd2, QN, QN, 1'b0, 1'b0},
    {3'd2, SN, P1, 1'b0, 1'b1},
    {3'd2, P1, P2, 1'b0, 1'b0},
    {3'd3, P1, P1, 1'b1, 1'b0},
    {3'd3, P1, P2, 1'b1, 1'b0},
    {3'd3, P2, P1, 1'b0, 1'b0},
    {3'd3, P1, QN, 1'b0, 1'b1},
    {3'd4, P1, P2, 1'b1, 1'b0},
    {3'd4, P2, P1, 1'b0, 1'b0},
    {3'd4, MI, P1, 1'b1, 1'b0},
    {3'd4, SN, P1, 1'b0, 1'b1},
    {3'd5, P1, P2, 1'b1, 1'b0},
    {3'd5, QN, P1, 1'b1, 1'b0},
    {3'd5, MZ, PZ, 1'b0, 1'b0},
    {3'd5, SN, SN, 1'b1, 1'b1},
    {3'd6, P2, P1, 1'b1, 1'b0},
    {3'd6, P1, P2, 1'b0, 1'b0},
    {3'd6, P1, P1, 1'b1, 1'b0},
    {3'd6, QN, P1, 1'b1, 1'b1},
    {3'd7, P1, P2, 1'b0, 1'b0},
    {3'd7, SN, P1, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        exc_cap_i = 1'b0, exc_en_i = 1'b0;
  logic [31:0] result_o;
  logic        result_valid_o, inv_flag_o, exc_req_o;
  logic [4:0]  exc_cause_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fcmp_unit u_fcmp_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .exc_cap_i, .exc_en_i,
    .result_o, .result_valid_o, .inv_flag_o, .exc_req_o, .exc_cause_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string op_req(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1, 3'd4: return "R4";
      3'd2, 3'd5: return "R3";
      3'd3, 3'd6: return "R5";
      default: return "R9";
    endcase
  endfunction

  // one strobed compare; returns on the falling edge after the capturing edge
  task automatic do_cmp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R11 reset state
    check("R11 result", result_o, 32'h0);
    check("R11 valid", {31'b0, result_valid_o}, 32'h0);
    check("R11 flag", {31'b0, inv_flag_o}, 32'h0);
    check("R11 req", {31'b0, exc_req_o}, 32'h0);
    check("R11 cause", {27'b0, exc_cause_o}, 32'h0);
    rst_ni = 1'b1;

    // table walk; R6 and R10 covered through invalid column
    exc_cap_i = 1'b1; exc_en_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      do_cmp(VEC[i][68:66], VEC[i][65:34], VEC[i][33:2]);
      check({op_req(VEC[i][68:66]), " R1 result"}, result_o, {31'b0, VEC[i][1]});
      check({op_req(VEC[i][68:66]), " R6 R10 invalid"}, {31'b0, exc_req_o}, {31'b0, VEC[i][0]});
    end
    check("R1 valid pulse", {31'b0, result_valid_o}, 32'h1);
    check("R8 cause", {27'b0, exc_cause_o}, 32'd6);
    check("R7 sticky after run", {31'b0, inv_flag_o}, 32'h1);

    // R12 idle hold
    @(negedge clk_i);
    op_i = 3'd0; a_i = SN; b_i = SN;
    @(negedge clk_i);
    check("R12 no valid", {31'b0, result_valid_o}, 32'h0);
    check("R12 result hold", result_o, 32'h0);
    check("R12 no req", {31'b0, exc_req_o}, 32'h0);

    // R7 cleared by reset, stays set across quiet compares
    do_reset();
    check("R7 cleared", {31'b0, inv_flag_o}, 32'h0);
    do_cmp(3'd2, QN, P1);
    check("R3 quiet no flag", {31'b0, inv_flag_o}, 32'h0);
    do_cmp(3'd1, QN, P1);
    check("R7 set", {31'b0, inv_flag_o}, 32'h1);
    do_cmp(3'd2, P1, P1);
    check("R7 stays", {31'b0, inv_flag_o}, 32'h1);
    check("R1 result", result_o, 32'h1);

    // R8 gating
    do_reset();
    exc_cap_i = 1'b0; exc_en_i = 1'b1;
    do_cmp(3'd0, SN, P1);
    check("R8 cap off req", {31'b0, exc_req_o}, 32'h0);
    check("R8 cap off cause", {27'b0, exc_cause_o}, 32'h0);
    check("R7 flag w/o exc", {31'b0, inv_flag_o}, 32'h1);
    exc_cap_i = 1'b1; exc_en_i = 1'b0;
    do_cmp(3'd6, QN, P1);
    check("R8 en off req", {31'b0, exc_req_o}, 32'h0);
    check("R8 en off cause", {27'b0, exc_cause_o}, 32'h0);
    exc_en_i = 1'b1;
    do_cmp(3'd5, SN, P1);
    check("R8 req", {31'b0, exc_req_o}, 32'h1);
    check("R8 cause loaded", {27'b0, exc_cause_o}, 32'd6);
    @(negedge clk_i);
    check("R8 pulse ends", {31'b0, exc_req_o}, 32'h0);
    check("R8 cause held", {27'b0, exc_cause_o}, 32'd6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule